// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block is the write side of a parallel NOR flash model that uses the classic unlock-cycle command protocol. Each bus write has a byte address and one data byte. The block tracks the unlock pair, the command cycle, the program data cycle and the two-stage erase sequence. It updates a small storage array that is organised in sectors. A read-side consumer sees the command that is active now, whether unlock bypass is on, and whether an operation is busy. The consumer reads array bytes through a combinational read port.

A program takes a fixed number of clock cycles. Chip erase and sector erase each take their own longer cycle count. An internal down-counter models all three durations, so a short simulation can see the device go from busy to ready. A read-only strap keeps the array unchanged but leaves the command protocol working. A one-cycle error pulse marks each write that breaks the protocol.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After synchronous reset, `active_cmd` is 0x00, `busy`, `bypass_on` and `seq_err` are 0, and every array byte reads 0xFF.
- R2: An unlock is data 0xAA at word offset UNLOCK0 followed by data 0x55 at word offset UNLOCK1. Any other write in read mode, and any wrong second unlock write, returns the block to read mode and raises `seq_err` for exactly the cycle after that write. The one exception in read mode is the query entry of R9.
- R3: The word offset used for every address match is the byte address within its sector shifted right by log2(DEV_BYTES). A sequence therefore matches in any sector and at either byte of a word.
- R4: The command cycle must be at word offset UNLOCK0 unless bypass is on. Data 0x80 starts erase setup, 0x90 enters autoselect, 0xA0 arms a program, and 0x20 turns bypass on and stays at the command cycle. Any other data, or a wrong address, resets the block with a `seq_err` pulse.
- R5: The program data write changes the addressed byte to old AND new. While `ro_strap` is 1 the array is not changed, but the operation still runs its busy period.
- R6: After 0x80, a second unlock pair is required. Then 0x10 at UNLOCK0 sets the whole array to 0xFF, and 0x30 at any address sets only the addressed sector to 0xFF. Any other write at this point resets the block with `seq_err`.
- R7: `busy` stays high for exactly PROG_CYC, SECT_CYC or CHIP_CYC cycles after a program, sector erase or chip erase starts. Every write during `busy` is ignored, including 0xF0.
- R8: Data 0xF0 outside `busy` returns the block to read mode and clears bypass with no `seq_err`. When a program is armed, 0xF0 is taken as program data instead.
- R9: Data 0x98 at word offset 0x55 enters query mode from read mode, from the erase-setup re-unlock step, or from autoselect. The next write leaves query mode; it raises `seq_err` unless its data is 0xF0.
- R10: With bypass on, the command cycle accepts any address. A finished program or erase returns to the command cycle with bypass still on. Data 0x00 in autoselect clears bypass and returns to read mode without `seq_err`.
- R11: `active_cmd` encodes the phase: 0x00 for read mode, unlock and the command cycle; 0x80 for the erase-setup steps; 0x90 for autoselect; 0x98 for query; 0xA0 for a program that is armed or running; 0x30 while a sector erase runs; 0x10 while a chip erase runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 8 | Write data byte |
| ro_strap | input | 1 | Array is read-only when 1 |
| rd_addr | input | ADDR_W | Byte address of the array read port |
| rd_data | output | 8 | Array byte at rd_addr (combinational) |
| active_cmd | output | 8 | Active command phase code (R11) |
| bypass_on | output | 1 | Unlock bypass is on |
| busy | output | 1 | Program or erase is running |
| seq_err | output | 1 | One-cycle pulse after a write that breaks the protocol |

## Verification
The embedded assertions check, on every cycle, that an error pulse only follows a write, that bypass turns on only after a 0x20 write, that a program never sets a stored bit, that an operation never starts while one is running, and that `busy` always shows a running-operation code. Only the bench scenarios can show the rest. These are the full accept and reject sets of each protocol step, word-offset matching in other sectors and on odd bytes, the exact busy lengths, which bytes each erase touches, the read-only strap, and the bypass round trips. They also cover the rule that a write made during busy leaves no trace.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    // Protocol data codes
    localparam logic [7:0] D_RESET      = 8'hF0;
    localparam logic [7:0] D_UNLOCK_A   = 8'hAA;
    localparam logic [7:0] D_UNLOCK_B   = 8'h55;
    localparam logic [7:0] D_ERASE_SET  = 8'h80;
    localparam logic [7:0] D_AUTOSEL    = 8'h90;
    localparam logic [7:0] D_PROGRAM    = 8'hA0;
    localparam logic [7:0] D_BYPASS     = 8'h20;
    localparam logic [7:0] D_QUERY      = 8'h98;
    localparam logic [7:0] D_CHIP_ERS   = 8'h10;
    localparam logic [7:0] D_SECT_ERS   = 8'h30;
    localparam logic [7:0] D_BYP_EXIT   = 8'h00;
    localparam int         QUERY_WORD   = 'h55;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL_B,
        ST_CMD,
        ST_E_UNL_A,
        ST_E_UNL_B,
        ST_E_CMD,
        ST_PDATA,
        ST_AUTO,
        ST_QUERY,
        ST_BUSY
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_PROG,
        OP_SECT,
        OP_CHIP
    } op_kind_e;

    typedef struct packed {
        logic     start;
        op_kind_e kind;
    } op_req_t;

    function automatic logic [7:0] phase_code(seq_state_e s, op_kind_e k);
        case (s)
            ST_E_UNL_A, ST_E_UNL_B, ST_E_CMD: phase_code = D_ERASE_SET;
            ST_AUTO:  phase_code = D_AUTOSEL;
            ST_QUERY: phase_code = D_QUERY;
            ST_PDATA: phase_code = D_PROGRAM;
            ST_BUSY: begin
                case (k)
                    OP_SECT: phase_code = D_SECT_ERS;
                    OP_CHIP: phase_code = D_CHIP_ERS;
                    default: phase_code = D_PROGRAM;
                endcase
            end
            default:  phase_code = 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
    import nor_cmd_pkg::*;
#(
    parameter int OFF_W   = 7,
    parameter int UNLOCK0 = 'h55,
    parameter int UNLOCK1 = 'h2A
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [7:0]       wr_data,
    input  logic             op_done,
    output op_req_t          req,
    output logic [7:0]       active_cmd,
    output logic             bypass,
    output logic             seq_err
);

    localparam logic [OFF_W-1:0] OFF_U0 = OFF_W'(UNLOCK0);
    localparam logic [OFF_W-1:0] OFF_U1 = OFF_W'(UNLOCK1);
    localparam logic [OFF_W-1:0] OFF_Q  = OFF_W'(QUERY_WORD);

    seq_state_e state_q, state_d;
    op_kind_e   kind_q, kind_d;
    logic       byp_d, bad;

    logic hit_a, hit_b, hit_q;
    assign hit_a = (wr_off == OFF_U0) && (wr_data == D_UNLOCK_A);
    assign hit_b = (wr_off == OFF_U1) && (wr_data == D_UNLOCK_B);
    assign hit_q = (wr_off == OFF_Q)  && (wr_data == D_QUERY);

    always_comb begin
        state_d   = state_q;
        kind_d    = kind_q;
        byp_d     = bypass;
        bad       = 1'b0;
        req.start = 1'b0;
        req.kind  = kind_q;
        if (state_q == ST_BUSY) begin
            if (op_done) state_d = bypass ? ST_CMD : ST_READ;
        end else if (wr_en) begin
            if (wr_data == D_RESET && state_q != ST_PDATA) begin
                state_d = ST_READ;
                byp_d   = 1'b0;
            end else begin
                case (state_q)
                    ST_READ: begin
                        if (hit_q)      state_d = ST_QUERY;
                        else if (hit_a) state_d = ST_UNL_B;
                        else            bad = 1'b1;
                    end
                    ST_UNL_B: begin
                        if (hit_b) state_d = ST_CMD;
                        else       bad = 1'b1;
                    end
                    ST_CMD: begin
                        if (!bypass && wr_off != OFF_U0) bad = 1'b1;
                        else begin
                            case (wr_data)
                                D_BYPASS:    byp_d   = 1'b1;
                                D_ERASE_SET: state_d = ST_E_UNL_A;
                                D_AUTOSEL:   state_d = ST_AUTO;
                                D_PROGRAM:   state_d = ST_PDATA;
                                default:     bad = 1'b1;
                            endcase
                        end
                    end
                    ST_E_UNL_A: begin
                        if (hit_q)      state_d = ST_QUERY;
                        else if (hit_a) state_d = ST_E_UNL_B;
                        else            bad = 1'b1;
                    end
                    ST_E_UNL_B: begin
                        if (hit_b) state_d = ST_E_CMD;
                        else       bad = 1'b1;
                    end
                    ST_E_CMD: begin
                        if (wr_data == D_CHIP_ERS && wr_off == OFF_U0) begin
                            req.start = 1'b1;
                            req.kind  = OP_CHIP;
                        end else if (wr_data == D_SECT_ERS) begin
                            req.start = 1'b1;
                            req.kind  = OP_SECT;
                        end else bad = 1'b1;
                    end
                    ST_PDATA: begin
                        req.start = 1'b1;
                        req.kind  = OP_PROG;
                    end
                    ST_AUTO: begin
                        if (bypass && wr_data == D_BYP_EXIT) begin
                            state_d = ST_READ;
                            byp_d   = 1'b0;
                        end else if (hit_q) state_d = ST_QUERY;
                        else                bad = 1'b1;
                    end
                    default: bad = 1'b1;
                endcase
                if (req.start) begin
                    state_d = ST_BUSY;
                    kind_d  = req.kind;
                end
                if (bad) begin
                    state_d = ST_READ;
                    byp_d   = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_READ;
            kind_q  <= OP_PROG;
            bypass  <= 1'b0;
            seq_err <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            bypass  <= byp_d;
            seq_err <= bad;
        end
    end

    assign active_cmd = phase_code(state_q, kind_q);

    // R2: an error pulse is always caused by a write in the cycle before
    assert_err_after_write_R2: assert property (@(posedge clk) disable iff (rst)
        seq_err |-> $past(wr_en));

endmodule

// File: rtl/nor_op_timer.sv
module nor_op_timer
    import nor_cmd_pkg::*;
#(
    parameter int PROG_CYC = 4,
    parameter int SECT_CYC = 24,
    parameter int CHIP_CYC = 48
) (
    input  logic    clk,
    input  logic    rst,
    input  op_req_t req,
    output logic    busy,
    output logic    done
);

    localparam int MAX_A = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
    localparam int MAX_C = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;
    localparam int CNT_W = $clog2(MAX_C + 1);

    logic [CNT_W-1:0] cnt_q, load;

    always_comb begin
        case (req.kind)
            OP_SECT: load = CNT_W'(SECT_CYC);
            OP_CHIP: load = CNT_W'(CHIP_CYC);
            default: load = CNT_W'(PROG_CYC);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)            cnt_q <= '0;
        else if (req.start) cnt_q <= load;
        else if (busy)      cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CNT_W'(1));

    // R7: the sequencer never launches an operation over a running one
    assert_start_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
        req.start |-> !busy);

    // R7: busy only ends through the completion cycle
    assert_busy_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);

endmodule

// File: rtl/nor_store.sv
module nor_store #(
    parameter int NUM_SECT   = 4,
    parameter int SECT_BYTES = 256,
    localparam int DEPTH     = NUM_SECT * SECT_BYTES,
    localparam int ADDR_W    = $clog2(DEPTH),
    localparam int SECT_W    = $clog2(NUM_SECT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    input  logic              sect_erase,
    input  logic [SECT_W-1:0] sect_idx,
    input  logic              chip_erase,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic [DEPTH*8-1:0] flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        localparam int SECT_OF = g / SECT_BYTES;
        logic [7:0] cell_q;
        always_ff @(posedge clk) begin
            if (rst)
                cell_q <= 8'hFF;
            else if (chip_erase || (sect_erase && sect_idx == SECT_W'(SECT_OF)))
                cell_q <= 8'hFF;
            else if (prog_en && prog_addr == ADDR_W'(g))
                cell_q <= cell_q & prog_data;
        end
        assign flat[g*8 +: 8] = cell_q;
    end

    assign rd_data = flat[{rd_addr, 3'b000} +: 8];

    // Checker state: old byte and address of the last program request
    logic [7:0]        chk_old;
    logic [ADDR_W-1:0] chk_addr;
    logic              chk_prog;
    always_ff @(posedge clk) begin
        chk_old  <= flat[{prog_addr, 3'b000} +: 8];
        chk_addr <= prog_addr;
        chk_prog <= prog_en && !chip_erase && !sect_erase;
    end

    // R5: a program step never turns a stored 0 into a 1
    assert_prog_clears_only_R5: assert property (@(posedge clk) disable iff (rst)
        chk_prog |-> ((flat[{chk_addr, 3'b000} +: 8] & ~chk_old) == 8'h00));

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int DEV_BYTES  = 2,
    parameter int SECT_BYTES = 256,
    parameter int NUM_SECT   = 4,
    parameter int UNLOCK0    = 'h55,
    parameter int UNLOCK1    = 'h2A,
    parameter int PROG_CYC   = 4,
    parameter int SECT_CYC   = 24,
    parameter int CHIP_CYC   = 48,
    localparam int DEPTH     = NUM_SECT * SECT_BYTES,
    localparam int ADDR_W    = $clog2(DEPTH),
    localparam int BOFF_W    = $clog2(SECT_BYTES),
    localparam int SHIFT     = $clog2(DEV_BYTES),
    localparam int OFF_W     = BOFF_W - SHIFT,
    localparam int SECT_W    = $clog2(NUM_SECT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              ro_strap,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic [7:0]        active_cmd,
    output logic              bypass_on,
    output logic              busy,
    output logic              seq_err
);

    op_req_t           req;
    logic              op_done;
    logic [OFF_W-1:0]  wr_off;
    logic [SECT_W-1:0] wr_sect;
    logic              do_prog, do_sect, do_chip;

    assign wr_off  = wr_addr[BOFF_W-1:SHIFT];
    assign wr_sect = wr_addr[ADDR_W-1:BOFF_W];

    assign do_prog = req.start && req.kind == OP_PROG && !ro_strap;
    assign do_sect = req.start && req.kind == OP_SECT && !ro_strap;
    assign do_chip = req.start && req.kind == OP_CHIP && !ro_strap;

    nor_seq_fsm #(
        .OFF_W  (OFF_W),
        .UNLOCK0(UNLOCK0),
        .UNLOCK1(UNLOCK1)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_off    (wr_off),
        .wr_data   (wr_data),
        .op_done   (op_done),
        .req       (req),
        .active_cmd(active_cmd),
        .bypass    (bypass_on),
        .seq_err   (seq_err)
    );

    nor_op_timer #(
        .PROG_CYC(PROG_CYC),
        .SECT_CYC(SECT_CYC),
        .CHIP_CYC(CHIP_CYC)
    ) u_timer (
        .clk (clk),
        .rst (rst),
        .req (req),
        .busy(busy),
        .done(op_done)
    );

    nor_store #(
        .NUM_SECT  (NUM_SECT),
        .SECT_BYTES(SECT_BYTES)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .prog_en   (do_prog),
        .prog_addr (wr_addr),
        .prog_data (wr_data),
        .sect_erase(do_sect),
        .sect_idx  (wr_sect),
        .chip_erase(do_chip),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    // R11: while busy the phase code names a running operation
    assert_busy_code_R11: assert property (@(posedge clk) disable iff (rst)
        busy |-> (active_cmd == D_PROGRAM || active_cmd == D_SECT_ERS ||
                  active_cmd == D_CHIP_ERS));

    // R10: bypass only turns on after a 0x20 command write
    assert_bypass_entry_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(bypass_on) |-> ($past(wr_en) && $past(wr_data) == D_BYPASS));

endmodule

// File: tb/nor_cmd_decoder_tb.sv
`timescale 1ns/1ps
module nor_cmd_decoder_tb_top;

    localparam int PROG_CYC = 4;
    localparam int SECT_CYC = 24;
    localparam int CHIP_CYC = 48;
    localparam int NV       = 36;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [9:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       ro_strap = 1'b0;
    logic [9:0] rd_addr = '0;
    logic [7:0] rd_data, active_cmd;
    logic       bypass_on, busy, seq_err;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    nor_cmd_decoder #(
        .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
    ) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ro_strap(ro_strap), .rd_addr(rd_addr),
        .rd_data(rd_data), .active_cmd(active_cmd), .bypass_on(bypass_on),
        .busy(busy), .seq_err(seq_err)
    );

    // {byte addr, data, expected active_cmd, expected seq_err, expected bypass}
    localparam logic [27:0] VEC [NV] = '{
        {10'h000, 8'h55, 8'h00, 1'b1, 1'b0},  // R2 stray write
        {10'h0AA, 8'hAA, 8'h00, 1'b0, 1'b0},
        {10'h054, 8'h55, 8'h00, 1'b0, 1'b0},
        {10'h0AA, 8'h90, 8'h90, 1'b0, 1'b0},  // R4 autoselect
        {10'h0AA, 8'h98, 8'h98, 1'b0, 1'b0},  // R9 query from autoselect
        {10'h000, 8'h12, 8'h00, 1'b1, 1'b0},  // R9 leave query
        {10'h0AA, 8'h98, 8'h98, 1'b0, 1'b0},  // R9 query from read
        {10'h300, 8'hF0, 8'h00, 1'b0, 1'b0},  // R8 reset
        {10'h0AA, 8'hAA, 8'h00, 1'b0, 1'b0},
        {10'h056, 8'h55, 8'h00, 1'b1, 1'b0},  // R2 wrong second address
        {10'h0AB, 8'hAA, 8'h00, 1'b0, 1'b0},  // R3 odd byte
        {10'h154, 8'h55, 8'h00, 1'b0, 1'b0},  // R3 other sector
        {10'h0AA, 8'h77, 8'h00, 1'b1, 1'b0},  // R4 unknown command
        {10'h0AA, 8'hAA, 8'h00, 1'b0, 1'b0},
        {10'h054, 8'h55, 8'h00, 1'b0, 1'b0},
        {10'h0AC, 8'h90, 8'h00, 1'b1, 1'b0},  // R4 wrong command address
        {10'h2AA, 8'hAA, 8'h00, 1'b0, 1'b0},
        {10'h054, 8'h55, 8'h00, 1'b0, 1'b0},
        {10'h0AA, 8'h20, 8'h00, 1'b0, 1'b1},  // R4 bypass on
        {10'h010, 8'h90, 8'h90, 1'b0, 1'b1},  // R10 any address
        {10'h010, 8'h00, 8'h00, 1'b0, 1'b0},  // R10 bypass exit
        {10'h0AA, 8'hAA, 8'h00, 1'b0, 1'b0},
        {10'h054, 8'h55, 8'h00, 1'b0, 1'b0},
        {10'h0AA, 8'h80, 8'h80, 1'b0, 1'b0},  // R11 erase setup
        {10'h0AA, 8'hAA, 8'h80, 1'b0, 1'b0},
        {10'h054, 8'h55, 8'h80, 1'b0, 1'b0},
        {10'h0AA, 8'h55, 8'h00, 1'b1, 1'b0},  // R6 bad erase code
        {10'h0AA, 8'hAA, 8'h00, 1'b0, 1'b0},
        {10'h054, 8'h55, 8'h00, 1'b0, 1'b0},
        {10'h0AA, 8'h80, 8'h80, 1'b0, 1'b0},
        {10'h0AA, 8'h55, 8'h00, 1'b1, 1'b0},  // R6 re-unlock needs 0xAA
        {10'h000, 8'hF0, 8'h00, 1'b0, 1'b0},  // R8 reset in read mode
        {10'h0AA, 8'hAA, 8'h00, 1'b0, 1'b0},
        {10'h054, 8'h55, 8'h00, 1'b0, 1'b0},
        {10'h0AA, 8'h90, 8'h90, 1'b0, 1'b0},
        {10'h010, 8'h00, 8'h00, 1'b1, 1'b0}   // R10 0x00 illegal without bypass
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        wr_addr = a;
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic unlock();
        wr(10'h0AA, 8'hAA);
        wr(10'h054, 8'h55);
    endtask

    task automatic rd(input logic [9:0] a, input logic [7:0] exp, input string tag);
        rd_addr = a;
        #0.5;
        chk(tag, rd_data, exp);
    endtask

    task automatic busy_len(input int exp, input string tag);
        int n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk(tag, n, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 cmd", active_cmd, 8'h00);
        chk("R1 busy", busy, 0);
        chk("R1 bypass", bypass_on, 0);
        chk("R1 err", seq_err, 0);
        rd(10'h000, 8'hFF, "R1 array");
        rd(10'h3FF, 8'hFF, "R1 array");

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][27:18], VEC[i][17:10]);
            chk($sformatf("R11 vec%0d cmd", i), active_cmd, VEC[i][9:2]);
            chk($sformatf("R2 vec%0d err", i), seq_err, VEC[i][1]);
            chk($sformatf("R10 vec%0d bypass", i), bypass_on, VEC[i][0]);
        end

        // R8/R5: 0xF0 as program data, busy length, writes ignored while busy
        unlock();
        wr(10'h0AA, 8'hA0);
        chk("R11 armed", active_cmd, 8'hA0);
        wr(10'h100, 8'hF0);
        chk("R7 busy", busy, 1);
        wr(10'h000, 8'hF0);
        chk("R7 F0 ignored", active_cmd, 8'hA0);
        busy_len(PROG_CYC - 1, "R7 prog length");
        chk("R7 back to read", active_cmd, 8'h00);
        rd(10'h100, 8'hF0, "R8 F0 programmed");
        unlock();
        wr(10'h0AA, 8'hA0);
        wr(10'h100, 8'h3C);
        busy_len(PROG_CYC, "R7 prog length");
        rd(10'h100, 8'h30, "R5 AND");

        // R5 read-only strap
        ro_strap = 1'b1;
        unlock();
        wr(10'h0AA, 8'hA0);
        wr(10'h101, 8'h00);
        busy_len(PROG_CYC, "R5 ro busy");
        rd(10'h101, 8'hFF, "R5 ro keeps");
        ro_strap = 1'b0;

        // program sector 2 byte, then sector 1 erase
        unlock();
        wr(10'h0AA, 8'hA0);
        wr(10'h200, 8'h00);
        busy_len(PROG_CYC, "R7 prog length");
        unlock();
        wr(10'h0AA, 8'h80);
        unlock();
        wr(10'h1FE, 8'h30);
        chk("R11 sector code", active_cmd, 8'h30);
        busy_len(SECT_CYC, "R7 sector length");
        rd(10'h100, 8'hFF, "R6 sector erased");
        rd(10'h200, 8'h00, "R6 other sector kept");

        // R10 bypass program round trip
        unlock();
        wr(10'h0AA, 8'h20);
        wr(10'h000, 8'hA0);
        chk("R10 bypass program", active_cmd, 8'hA0);
        wr(10'h203, 8'h5A);
        busy_len(PROG_CYC, "R7 prog length");
        chk("R10 stays bypass", bypass_on, 1);
        chk("R10 cmd cycle", active_cmd, 8'h00);
        rd(10'h203, 8'h5A, "R10 programmed");
        wr(10'h3F0, 8'hA0);
        chk("R10 second program", active_cmd, 8'hA0);
        wr(10'h204, 8'h0F);
        busy_len(PROG_CYC, "R7 prog length");
        wr(10'h000, 8'hF0);
        chk("R8 clears bypass", bypass_on, 0);
        chk("R8 no err", seq_err, 0);

        // R6 chip erase: wrong address, then correct
        unlock();
        wr(10'h0AA, 8'h80);
        unlock();
        wr(10'h0AC, 8'h10);
        chk("R6 chip wrong addr", seq_err, 1);
        chk("R6 chip wrong busy", busy, 0);
        unlock();
        wr(10'h0AA, 8'h80);
        unlock();
        wr(10'h0AA, 8'h10);
        chk("R11 chip code", active_cmd, 8'h10);
        busy_len(CHIP_CYC, "R7 chip length");
        rd(10'h200, 8'hFF, "R6 chip erased");
        rd(10'h204, 8'hFF, "R6 chip erased");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(negedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R7 watchdog: got hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule